// File: doc/BRIEF.md
# Signed multiply-accumulate unit

This block multiplies two signed 16-bit operands and adds the product into a 42-bit internal accumulator. A mode input picks one of two accumulation behaviours that share the same register. In saturating mode the running sum is held inside the signed 32-bit range and clamps at either end. In wrap mode the full 42-bit sum is kept and overflows modulo 2^42.

Separate command strobes clear the accumulator, load it from a 32-bit value, and capture it onto a pair of read ports. Operands are presented directly on data ports, so there is no address generation and no instruction decoding. The only status output is a sticky saturation flag. A done pulse marks each accumulate that takes effect.

Top module: `smac_unit`

## Requirements
- R1: While rst_ni is low and after reset, the accumulator is zero, and sat_o, done_o and rd_valid_o are 0, with rd_hi_o and rd_lo_o zero.
- R2: When sat_mode_i = 0, an accepted accumulate sets the accumulator to its old value plus the signed product op_a_i*op_b_i, modulo 2^42.
- R3: When sat_mode_i = 1, an accepted accumulate stores the sum limited to [-2^31, 2^31-1]. A positive overflow gives 0x7FFFFFFF and a negative one gives 0x80000000, and the result is held sign-extended to 42 bits.
- R4: sat_o goes to 1 after any accumulate that clamps, and stays 1 until a clear or a reset.
- R5: clr_i zeroes the accumulator and sat_o at the next edge. It has priority over ld_i and mac_valid_i.
- R6: ld_i (without clr_i) loads ld_data_i sign-extended into all 42 bits, and it has priority over mac_valid_i.
- R7: st_i captures the accumulator value held at that edge, before any same-edge update. In the next cycle rd_valid_o = 1, rd_lo_o = bits 31:0, and rd_hi_o = bits 41:32 sign-extended to 32 bits. The read ports hold their value until the next st_i.
- R8: done_o is 1 for exactly the cycle after an edge where mac_valid_i was accepted, meaning neither clr_i nor ld_i was high. Otherwise it is 0.
- R9: Changing sat_mode_i never alters the stored bits. In saturating mode, a stored value outside the 32-bit range is first clamped before the product is added, and that clamp sets sat_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sat_mode_i | input | 1 | 1 = saturating 32-bit, 0 = wrapping 42-bit |
| clr_i | input | 1 | Clear accumulator and saturation flag |
| ld_i | input | 1 | Load accumulator from ld_data_i |
| ld_data_i | input | 32 | Signed load value |
| mac_valid_i | input | 1 | Accumulate strobe |
| op_a_i | input | 16 | Signed multiplicand |
| op_b_i | input | 16 | Signed multiplier |
| st_i | input | 1 | Capture accumulator to read ports |
| done_o | output | 1 | Accumulate took effect last edge |
| rd_valid_o | output | 1 | Read ports updated last edge |
| rd_hi_o | output | 32 | Accumulator bits 41:32, sign-extended |
| rd_lo_o | output | 32 | Accumulator bits 31:0 |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The accumulator is visible only through a store, so a corrupted value stays hidden until st_i is pulsed. It then appears on rd_hi_o/rd_lo_o one cycle later. For this reason the bench stores after almost every operation, and any wrong state surfaces within two cycles of the operation that caused it. A wrong clamp or a lost priority also appears at once on sat_o or done_o. An error in the 42-bit upper bits only becomes visible through rd_hi_o, so long runs of accumulates in wrap mode are read back in full.

// File: rtl/smac_pkg.sv
package smac_pkg;
  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_CLR,
    CMD_LOAD,
    CMD_MAC
  } smac_cmd_e;
endpackage

// File: rtl/smac_cmd_arb.sv
module smac_cmd_arb
  import smac_pkg::*;
(
  input  logic      clr_i,
  input  logic      ld_i,
  input  logic      mac_i,
  output smac_cmd_e cmd_o
);
  // fixed priority: clear > load > accumulate
  always_comb begin
    if (clr_i)      cmd_o = CMD_CLR;
    else if (ld_i)  cmd_o = CMD_LOAD;
    else if (mac_i) cmd_o = CMD_MAC;
    else            cmd_o = CMD_NONE;
  end
endmodule

// File: rtl/smac_mul.sv
module smac_mul #(
  parameter int OP_W = 16
) (
  input  logic signed [OP_W-1:0]   a_i,
  input  logic signed [OP_W-1:0]   b_i,
  output logic signed [2*OP_W-1:0] p_o
);
  assign p_o = a_i * b_i;
endmodule

// File: rtl/smac_sum.sv
module smac_sum #(
  parameter int PROD_W = 32,
  parameter int SAT_W  = 32,
  parameter int ACC_W  = 42
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [PROD_W-1:0] prod_i,
  input  logic              sat_mode_i,
  output logic [ACC_W-1:0]  nxt_o,
  output logic              clip_o
);
  localparam int TOP_W = ACC_W - SAT_W + 1;
  localparam logic [SAT_W-1:0] SAT_MAX = {1'b0, {(SAT_W-1){1'b1}}};
  localparam logic [SAT_W-1:0] SAT_MIN = {1'b1, {(SAT_W-1){1'b0}}};

  logic [TOP_W-1:0] top_bits;
  logic             fits;
  logic [SAT_W-1:0] base;
  logic [SAT_W:0]   prod_s;
  logic [SAT_W:0]   sum_s;
  logic             ovf;
  logic [SAT_W-1:0] sat_res;
  logic [ACC_W-1:0] wrap_res;

  always_comb begin
    top_bits = acc_i[ACC_W-1:SAT_W-1];
    fits     = (top_bits == '0) || (top_bits == '1);
    // pre-clamp a wide value left over from wrap mode
    base     = fits ? acc_i[SAT_W-1:0] : (acc_i[ACC_W-1] ? SAT_MIN : SAT_MAX);
    prod_s   = {{(SAT_W+1-PROD_W){prod_i[PROD_W-1]}}, prod_i};
    sum_s    = {base[SAT_W-1], base} + prod_s;
    ovf      = sum_s[SAT_W] ^ sum_s[SAT_W-1];
    sat_res  = ovf ? (sum_s[SAT_W] ? SAT_MIN : SAT_MAX) : sum_s[SAT_W-1:0];
    wrap_res = acc_i + {{(ACC_W-PROD_W){prod_i[PROD_W-1]}}, prod_i};
    nxt_o    = sat_mode_i ? {{(ACC_W-SAT_W){sat_res[SAT_W-1]}}, sat_res} : wrap_res;
    clip_o   = sat_mode_i & (~fits | ovf);
  end
endmodule

// File: rtl/smac_unit.sv
module smac_unit
  import smac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int SAT_W = 32,
  parameter int ACC_W = 42
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sat_mode_i,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [SAT_W-1:0] ld_data_i,
  input  logic             mac_valid_i,
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  input  logic             st_i,
  output logic             done_o,
  output logic             rd_valid_o,
  output logic [SAT_W-1:0] rd_hi_o,
  output logic [SAT_W-1:0] rd_lo_o,
  output logic             sat_o
);
  localparam int PROD_W = 2 * OP_W;
  localparam int EXT_W  = ACC_W - SAT_W;
  localparam int HI_PAD = 2 * SAT_W - ACC_W;

  smac_cmd_e        cmd;
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  acc_nxt;
  logic              clip;
  logic [ACC_W-1:0]  acc_q;
  logic              sat_q;
  logic              done_q;
  logic              rd_v_q;
  logic [SAT_W-1:0]  rd_hi_q;
  logic [SAT_W-1:0]  rd_lo_q;

  smac_cmd_arb u_arb (
    .clr_i (clr_i),
    .ld_i  (ld_i),
    .mac_i (mac_valid_i),
    .cmd_o (cmd)
  );

  smac_mul #(.OP_W(OP_W)) u_mul (
    .a_i (op_a_i),
    .b_i (op_b_i),
    .p_o (prod)
  );

  smac_sum #(.PROD_W(PROD_W), .SAT_W(SAT_W), .ACC_W(ACC_W)) u_sum (
    .acc_i      (acc_q),
    .prod_i     (prod),
    .sat_mode_i (sat_mode_i),
    .nxt_o      (acc_nxt),
    .clip_o     (clip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      sat_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= (cmd == CMD_MAC);
      unique case (cmd)
        CMD_CLR: begin
          acc_q <= '0;
          sat_q <= 1'b0;
        end
        CMD_LOAD: acc_q <= {{EXT_W{ld_data_i[SAT_W-1]}}, ld_data_i};
        CMD_MAC: begin
          acc_q <= acc_nxt;
          if (clip) sat_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // read ports capture the pre-update value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_v_q  <= 1'b0;
      rd_hi_q <= '0;
      rd_lo_q <= '0;
    end else begin
      rd_v_q <= st_i;
      if (st_i) begin
        rd_lo_q <= acc_q[SAT_W-1:0];
        rd_hi_q <= {{HI_PAD{acc_q[ACC_W-1]}}, acc_q[ACC_W-1:SAT_W]};
      end
    end
  end

  assign done_o     = done_q;
  assign rd_valid_o = rd_v_q;
  assign rd_hi_o    = rd_hi_q;
  assign rd_lo_o    = rd_lo_q;
  assign sat_o      = sat_q;

  AST_RESET_IDLE: assert property (@(posedge clk_i) !rst_ni |=> (acc_q == '0 || !rst_ni)); // R1
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mac_valid_i && !clr_i && !ld_i)); // R8
  AST_DONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_valid_i && !clr_i && !ld_i) |=> done_o); // R8
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0 && !sat_o)); // R5
  AST_LD_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !clr_i) |=> (acc_q == {{EXT_W{$past(ld_data_i[SAT_W-1])}}, $past(ld_data_i)})); // R6
  AST_SAT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_valid_i && !clr_i && !ld_i && sat_mode_i) |=>
      (acc_q[ACC_W-1:SAT_W-1] == '0 || acc_q[ACC_W-1:SAT_W-1] == '1)); // R3
  AST_SAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && !clr_i) |=> sat_o); // R4
  AST_RD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(st_i)); // R7
  AST_MODE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_i && !mac_valid_i) |=> $stable(acc_q)); // R9
endmodule

// File: tb/smac_unit_bench.sv
module smac_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sat_mode_i = 1'b0;
  logic        clr_i = 1'b0;
  logic        ld_i = 1'b0;
  logic [31:0] ld_data_i = '0;
  logic        mac_valid_i = 1'b0;
  logic [15:0] op_a_i = '0;
  logic [15:0] op_b_i = '0;
  logic        st_i = 1'b0;
  logic        done_o;
  logic        rd_valid_o;
  logic [31:0] rd_hi_o;
  logic [31:0] rd_lo_o;
  logic        sat_o;

  int n_chk = 0;
  int n_fail = 0;
  logic signed [41:0] m_acc = '0;
  logic               m_sat = 1'b0;

  always #5ns clk_i = ~clk_i;

  smac_unit u_smac_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .sat_mode_i(sat_mode_i), .clr_i(clr_i),
    .ld_i(ld_i), .ld_data_i(ld_data_i), .mac_valid_i(mac_valid_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .st_i(st_i), .done_o(done_o),
    .rd_valid_o(rd_valid_o), .rd_hi_o(rd_hi_o), .rd_lo_o(rd_lo_o), .sat_o(sat_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic mdl_mac(input logic signed [15:0] a, input logic signed [15:0] b);
    longint p, base, s;
    p = longint'(a) * longint'(b);
    if (sat_mode_i) begin
      base = longint'(m_acc);
      if (base > 64'sd2147483647) begin base = 64'sd2147483647; m_sat = 1'b1; end
      if (base < -64'sd2147483648) begin base = -64'sd2147483648; m_sat = 1'b1; end
      s = base + p;
      if (s > 64'sd2147483647) begin s = 64'sd2147483647; m_sat = 1'b1; end
      if (s < -64'sd2147483648) begin s = -64'sd2147483648; m_sat = 1'b1; end
      m_acc = s[41:0];
    end else begin
      s = longint'(m_acc) + p;
      m_acc = s[41:0];
    end
  endtask

  task automatic do_mac(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk_i);
    op_a_i = a; op_b_i = b; mac_valid_i = 1'b1;
    mdl_mac(a, b);
    @(negedge clk_i);
    mac_valid_i = 1'b0;
    chk("R8 done pulse", {63'd0, done_o}, 64'd1);
  endtask

  task automatic do_ld(input logic [31:0] d);
    @(negedge clk_i);
    ld_i = 1'b1; ld_data_i = d;
    m_acc = {{10{d[31]}}, d};
    @(negedge clk_i);
    ld_i = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk_i);
    clr_i = 1'b1;
    m_acc = '0; m_sat = 1'b0;
    @(negedge clk_i);
    clr_i = 1'b0;
  endtask

  task automatic do_st(input string req);
    @(negedge clk_i);
    st_i = 1'b1;
    @(negedge clk_i);
    st_i = 1'b0;
    chk(req, {63'd0, rd_valid_o}, 64'd1);
    chk(req, {32'd0, rd_lo_o}, {32'd0, m_acc[31:0]});
    chk(req, {32'd0, rd_hi_o}, {32'd0, {22{m_acc[41]}}, m_acc[41:32]});
    chk("R4 sat flag", {63'd0, sat_o}, {63'd0, m_sat});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk_i);
    chk("R1 done", {63'd0, done_o}, 64'd0);
    chk("R1 rd_valid", {63'd0, rd_valid_o}, 64'd0);
    chk("R1 sat", {63'd0, sat_o}, 64'd0);
    chk("R1 rd_lo", {32'd0, rd_lo_o}, 64'd0);
    rst_ni = 1'b1;
    do_st("R1 acc zero");

    // R2 basic wrap mode
    do_mac(16'd300, 16'hFF9C);
    do_st("R2 signed product");
    do_mac(16'h7FFF, 16'h7FFF);
    do_st("R2 accumulate");

    // R3 positive clamp
    sat_mode_i = 1'b1;
    do_ld(32'h7FFF_FFF0);
    do_mac(16'd100, 16'd100);
    do_st("R3 positive clamp");
    chk("R3 max value", {32'd0, rd_lo_o}, 64'h7FFF_FFFF);
    do_clr();
    do_st("R5 clear zeroes flag");
    do_ld(32'h8000_0010);
    do_mac(16'hFF00, 16'd100);
    do_st("R3 negative clamp");
    chk("R3 min value", {32'd0, rd_lo_o}, 64'h8000_0000);

    // R5 clear beats accumulate and load
    @(negedge clk_i);
    clr_i = 1'b1; ld_i = 1'b1; ld_data_i = 32'h1234; mac_valid_i = 1'b1;
    op_a_i = 16'd5; op_b_i = 16'd5;
    m_acc = '0; m_sat = 1'b0;
    @(negedge clk_i);
    clr_i = 1'b0; ld_i = 1'b0; mac_valid_i = 1'b0;
    chk("R8 no done on clear", {63'd0, done_o}, 64'd0);
    do_st("R5 clear priority");

    // R6 load beats accumulate
    @(negedge clk_i);
    ld_i = 1'b1; ld_data_i = 32'hF000_0001; mac_valid_i = 1'b1;
    m_acc = {{10{1'b1}}, 32'hF000_0001};
    @(negedge clk_i);
    ld_i = 1'b0; mac_valid_i = 1'b0;
    chk("R8 no done on load", {63'd0, done_o}, 64'd0);
    do_st("R6 load sign extend");

    // R7 store sees pre-update value
    @(negedge clk_i);
    st_i = 1'b1; mac_valid_i = 1'b1; op_a_i = 16'd7; op_b_i = 16'd9;
    @(negedge clk_i);
    st_i = 1'b0; mac_valid_i = 1'b0;
    chk("R7 old value", {32'd0, rd_lo_o}, {32'd0, m_acc[31:0]});
    mdl_mac(16'd7, 16'd9);
    do_st("R7 after update");

    // R9 wide value, then mode switch
    sat_mode_i = 1'b0;
    do_clr();
    do_ld(32'h7FFF_FFFF);
    do_mac(16'h7FFF, 16'h7FFF);
    do_st("R2 beyond 32 bits");
    sat_mode_i = 1'b1;
    do_st("R9 mode switch keeps bits");
    do_mac(16'd0, 16'd0);
    do_st("R9 pre-clamp on entry");
    chk("R9 clamped max", {32'd0, rd_lo_o}, 64'h7FFF_FFFF);

    // R2 42-bit wrap
    sat_mode_i = 1'b0;
    do_clr();
    for (int i = 0; i < 2048; i++) do_mac(16'h8000, 16'h8000);
    do_st("R2 wrap at 2^41");
    chk("R2 hi wraps", {32'd0, rd_hi_o}, 64'hFFFF_FE00);

    // random mix
    for (int i = 0; i < 400; i++) begin
      r = $urandom;
      case (r[2:0])
        3'd0: do_clr();
        3'd1: do_ld($urandom);
        3'd2: sat_mode_i = ~sat_mode_i;
        default: do_mac(16'($urandom), 16'($urandom));
      endcase
      do_st(sat_mode_i ? "R3 random" : "R2 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule